// File: doc/BRIEF.md
# Transfer Descriptor Fetch Sequencer

This block loads the settings for one transfer of an interrupt-driven data mover before the transfer engine begins work. An activation names a 7-bit vector. The sequencer first reads a 16-bit pointer from a vector table in low memory. It then prefixes that pointer with the fixed top address byte of the on-chip RAM window, which gives the descriptor's byte address. Starting there it reads three 32-bit words and splits them into two 8-bit mode fields, a 24-bit source address, a 24-bit destination address and two 16-bit counts.

After a descriptor has been loaded, a chain request fetches the descriptor stored immediately after it. This fetch goes straight to memory and skips the vector table. The memory side has one outstanding access at a time, using a request/ready pair and a flag that selects a halfword read. Every fetch finishes with a single-cycle done pulse or a single-cycle error pulse.

Top module: `desc_fetch_seq`

## Requirements
- R1: An accepted activation first issues a halfword read (`memHalf`=1) at byte address 0x000400 + 2 × vector, zero-extended to 24 bits. The pointer is taken from `memRdata[15:0]`.
- R2: The descriptor start address is {0xFF, pointer}. Only after the pointer read completes are three full-word reads issued, at start, start+4 and start+8, strictly in that order.
- R3: Word 0 supplies mode A in bits 31:24 and the source address in bits 23:0. Word 1 supplies mode B and the destination address the same way. Word 2 supplies count A in bits 31:16 and count B in bits 15:0.
- R4: A pointer whose start address is not a multiple of four produces a one-cycle `fetchErr` in the cycle after the pointer read completes. No word read is issued, and the descriptor outputs and `descAddr` keep their previous values.
- R5: A start address below 0xFFEC00, or above 0xFFEFF4 (the whole 12-byte descriptor must fit below 0xFFF000), is rejected exactly as in R4.
- R6: A chain request in idle reads the next descriptor at the previous start + 12, with no vector read. If that address breaks R5, or no descriptor has been loaded since reset, `fetchErr` pulses in the cycle after the request and no memory access is made.
- R7: `fetchDone` is high for exactly one cycle: the cycle after the last word read completes. With W wait cycles per access, this is 4(W+1)+1 cycles after an activation and 3(W+1)+1 cycles after a chain request. `busy` is high from the cycle after acceptance until the fetch ends.
- R8: While `memReq` is high and `memReady` low, `memReq`, `memAddr` and `memHalf` hold steady.
- R9: Activations and chain requests that arrive while `busy` is high are ignored. They do not change the access sequence or the loaded fields.
- R10: If an activation and a chain request arrive in the same idle cycle, the activation is taken.
- R11: In reset, `busy`, `memReq`, `fetchDone`, `fetchErr`, `descAddr` and every descriptor field are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| actValid | input | 1 | Activation request, sampled in idle |
| actVector | input | 7 | Vector number of the activation |
| chainReq | input | 1 | Request to fetch the next chained descriptor |
| memReq | output | 1 | Memory read request |
| memHalf | output | 1 | 1: halfword read, 0: full-word read |
| memAddr | output | 24 | Byte address of the read |
| memReady | input | 1 | Read data valid; ends the access |
| memRdata | input | 32 | Read data (halfword in bits 15:0) |
| busy | output | 1 | A fetch is in progress |
| fetchDone | output | 1 | One-cycle pulse: descriptor loaded |
| fetchErr | output | 1 | One-cycle pulse: fetch rejected |
| descAddr | output | 24 | Start address of the loaded descriptor |
| descModeA | output | 8 | Mode A field |
| descSrc | output | 24 | Source address field |
| descModeB | output | 8 | Mode B field |
| descDst | output | 24 | Destination address field |
| descCountA | output | 16 | Count A field |
| descCountB | output | 16 | Count B field |

## Verification
All inputs are driven on the falling edge, and the bench counts falling edges from the stimulus edge, where the first edge after driving is cycle 1. With W wait cycles per access, the bench expects a done pulse at cycle 4(W+1)+1 after an activation and 3(W+1)+1 after a chain request. A pointer rejected for range or alignment raises its error at cycle W+2, and a rejected chain request raises its error at cycle 1. At the first falling edge where either pulse is seen, the measured count is compared with that number. The next edge is then checked for the pulse having cleared and `busy` being low. The memory model logs every completed access, so both the order and the number of reads are compared as well.

// File: rtl/desc_fetch_pkg.sv
package desc_fetch_pkg;

  // number of 32-bit words making up one descriptor
  localparam int DESC_WORDS = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_VEC  = 2'd1,
    ST_WORD = 2'd2
  } fetchState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic                  ldVec;    // load vector-table address
    logic                  ldPtr;    // accept pointer as descriptor start
    logic                  ldChain;  // advance to the chained descriptor
    logic [DESC_WORDS-1:0] capWord;  // capture descriptor word i
  } dpStrobe_t;

endpackage

// File: rtl/desc_fetch_dp.sv
module desc_fetch_dp
  import desc_fetch_pkg::*;
#(
  parameter int VEC_W = 7,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int PTR_W = 16,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 24'h000400,
  parameter logic [ADDR_W-1:0] WIN_LO = 24'hFFEC00,
  parameter logic [ADDR_W-1:0] WIN_HI = 24'hFFEFFF,
  localparam int MODE_W = DATA_W - ADDR_W,
  localparam int CNT_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [VEC_W-1:0]  actVector,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] addrQ,
  output logic [ADDR_W-1:0] baseQ,
  output logic              ptrOk,
  output logic              chainOk,
  output logic [MODE_W-1:0] modeA,
  output logic [ADDR_W-1:0] srcAddr,
  output logic [MODE_W-1:0] modeB,
  output logic [ADDR_W-1:0] dstAddr,
  output logic [CNT_W-1:0]  countA,
  output logic [CNT_W-1:0]  countB
);

  localparam int BYTES_PER_WORD = DATA_W / 8;
  localparam int ALIGN_BITS = $clog2(BYTES_PER_WORD);
  localparam int DESC_BYTES = DESC_WORDS * BYTES_PER_WORD;
  localparam logic [ADDR_W-1:0] DESC_SPAN = ADDR_W'(DESC_BYTES);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(BYTES_PER_WORD);
  localparam logic [ADDR_W-1:0] LAST_START = WIN_HI - DESC_SPAN + ADDR_W'(1);
  localparam logic [ADDR_W-PTR_W-1:0] PAGE = WIN_LO[ADDR_W-1:PTR_W];

  logic [ADDR_W-1:0] vecAddr;
  logic [ADDR_W-1:0] ptrCand;
  logic [ADDR_W-1:0] chainCand;
  logic              haveDesc;
  logic [DATA_W-1:0] wordQ [DESC_WORDS];

  // a start address is usable when aligned and the whole descriptor fits the window
  function automatic logic fitsWindow(input logic [ADDR_W-1:0] a);
    return (a[ALIGN_BITS-1:0] == '0) && (a >= WIN_LO) && (a <= LAST_START);
  endfunction

  assign vecAddr   = TABLE_BASE + ADDR_W'({actVector, 1'b0});
  assign ptrCand   = {PAGE, memRdata[PTR_W-1:0]};
  assign chainCand = baseQ + DESC_SPAN;
  assign ptrOk     = fitsWindow(ptrCand);
  assign chainOk   = haveDesc && fitsWindow(chainCand);

  // access address and descriptor base
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      baseQ    <= '0;
      haveDesc <= 1'b0;
    end else begin
      if (strobe.ldVec) begin
        addrQ <= vecAddr;
      end else if (strobe.ldPtr) begin
        addrQ <= ptrCand;
        baseQ <= ptrCand;
      end else if (strobe.ldChain) begin
        addrQ <= chainCand;
        baseQ <= chainCand;
      end else if (|strobe.capWord) begin
        addrQ <= addrQ + WORD_STEP;
      end
      if (strobe.capWord[DESC_WORDS-1]) begin
        haveDesc <= 1'b1;
      end
    end
  end

  // one capture register per descriptor word
  for (genvar i = 0; i < DESC_WORDS; i++) begin : gWord
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wordQ[i] <= '0;
      end else if (strobe.capWord[i]) begin
        wordQ[i] <= memRdata;
      end
    end

    // R2: word i is read at base + i words
    a_r2_word_offset: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capWord[i] |-> (addrQ == baseQ + ADDR_W'(i * BYTES_PER_WORD)));
  end

  // field unpacking
  assign modeA   = wordQ[0][DATA_W-1:ADDR_W];
  assign srcAddr = wordQ[0][ADDR_W-1:0];
  assign modeB   = wordQ[1][DATA_W-1:ADDR_W];
  assign dstAddr = wordQ[1][ADDR_W-1:0];
  assign countA  = wordQ[2][DATA_W-1:CNT_W];
  assign countB  = wordQ[2][CNT_W-1:0];

  // R5: a loaded descriptor always sits wholly inside the window, aligned
  a_r5_base_in_window: assert property (@(posedge clk) disable iff (!rstN)
    haveDesc |-> fitsWindow(baseQ));

endmodule

// File: rtl/desc_fetch_ctrl.sv
module desc_fetch_ctrl
  import desc_fetch_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      actValid,
  input  logic      chainReq,
  input  logic      memReady,
  input  logic      ptrOk,
  input  logic      chainOk,
  output dpStrobe_t strobe,
  output logic      memReq,
  output logic      memHalf,
  output logic      busy,
  output logic      fetchDone,
  output logic      fetchErr
);

  localparam int IDX_W = $clog2(DESC_WORDS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DESC_WORDS - 1);

  fetchState_t     state;
  fetchState_t     stateNext;
  logic [IDX_W-1:0] wordIdx;
  logic            doneSet;
  logic            errSet;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (actValid) begin
          strobe.ldVec = 1'b1;
          stateNext    = ST_VEC;
        end else if (chainReq) begin
          if (chainOk) begin
            strobe.ldChain = 1'b1;
            stateNext      = ST_WORD;
          end else begin
            errSet = 1'b1;
          end
        end
      end
      ST_VEC: begin
        if (memReady) begin
          if (ptrOk) begin
            strobe.ldPtr = 1'b1;
            stateNext    = ST_WORD;
          end else begin
            errSet    = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      ST_WORD: begin
        if (memReady) begin
          for (int i = 0; i < DESC_WORDS; i++) begin
            strobe.capWord[i] = (wordIdx == IDX_W'(i));
          end
          if (wordIdx == LAST_IDX) begin
            doneSet   = 1'b1;
            stateNext = ST_IDLE;
          end
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      wordIdx   <= '0;
      fetchDone <= 1'b0;
      fetchErr  <= 1'b0;
    end else begin
      state     <= stateNext;
      fetchDone <= doneSet;
      fetchErr  <= errSet;
      if (strobe.ldPtr || strobe.ldChain) begin
        wordIdx <= '0;
      end else if (|strobe.capWord) begin
        wordIdx <= wordIdx + IDX_W'(1);
      end
    end
  end

  assign memReq  = (state != ST_IDLE);
  assign memHalf = (state == ST_VEC);
  assign busy    = memReq;

  // R7: completion is a single-cycle pulse
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rstN)
    fetchDone |=> !fetchDone);

  // R4: a fetch ends either loaded or rejected, never both
  a_r4_outcome_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(fetchDone && fetchErr));

  // R9: a fetch in flight is left only through a completed access
  a_r9_busy_holds: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !memReady) |=> busy);

  // R2: the pointer read precedes every word read of an activation
  a_r2_ptr_first: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && actValid) |=> memHalf);

endmodule

// File: rtl/desc_fetch_seq.sv
module desc_fetch_seq
  import desc_fetch_pkg::*;
#(
  parameter int VEC_W = 7,
  parameter int ADDR_W = 24,
  parameter int DATA_W = 32,
  parameter int PTR_W = 16,
  parameter logic [ADDR_W-1:0] TABLE_BASE = 24'h000400,
  parameter logic [ADDR_W-1:0] WIN_LO = 24'hFFEC00,
  parameter logic [ADDR_W-1:0] WIN_HI = 24'hFFEFFF,
  localparam int MODE_W = DATA_W - ADDR_W,
  localparam int CNT_W = DATA_W / 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              actValid,
  input  logic [VEC_W-1:0]  actVector,
  input  logic              chainReq,
  output logic              memReq,
  output logic              memHalf,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memReady,
  input  logic [DATA_W-1:0] memRdata,
  output logic              busy,
  output logic              fetchDone,
  output logic              fetchErr,
  output logic [ADDR_W-1:0] descAddr,
  output logic [MODE_W-1:0] descModeA,
  output logic [ADDR_W-1:0] descSrc,
  output logic [MODE_W-1:0] descModeB,
  output logic [ADDR_W-1:0] descDst,
  output logic [CNT_W-1:0]  descCountA,
  output logic [CNT_W-1:0]  descCountB
);

  dpStrobe_t         strobe;
  logic              ptrOk;
  logic              chainOk;
  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] baseQ;

  desc_fetch_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .actValid (actValid),
    .chainReq (chainReq),
    .memReady (memReady),
    .ptrOk    (ptrOk),
    .chainOk  (chainOk),
    .strobe   (strobe),
    .memReq   (memReq),
    .memHalf  (memHalf),
    .busy     (busy),
    .fetchDone(fetchDone),
    .fetchErr (fetchErr)
  );

  desc_fetch_dp #(
    .VEC_W     (VEC_W),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PTR_W     (PTR_W),
    .TABLE_BASE(TABLE_BASE),
    .WIN_LO    (WIN_LO),
    .WIN_HI    (WIN_HI)
  ) uDp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .actVector(actVector),
    .memRdata (memRdata),
    .addrQ    (addrQ),
    .baseQ    (baseQ),
    .ptrOk    (ptrOk),
    .chainOk  (chainOk),
    .modeA    (descModeA),
    .srcAddr  (descSrc),
    .modeB    (descModeB),
    .dstAddr  (descDst),
    .countA   (descCountA),
    .countB   (descCountB)
  );

  assign memAddr  = addrQ;
  assign descAddr = baseQ;

  // R8: an access that has not been granted keeps its request steady
  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memAddr) && $stable(memHalf)));

endmodule

// File: tb/desc_fetch_seq_test.sv
module desc_fetch_seq_test;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        actValid = 1'b0;
  logic [6:0]  actVector = '0;
  logic        chainReq = 1'b0;
  logic        memReq;
  logic        memHalf;
  logic [23:0] memAddr;
  logic        memReady = 1'b0;
  logic [31:0] memRdata = '0;
  logic        busy;
  logic        fetchDone;
  logic        fetchErr;
  logic [23:0] descAddr;
  logic [7:0]  descModeA;
  logic [23:0] descSrc;
  logic [7:0]  descModeB;
  logic [23:0] descDst;
  logic [15:0] descCountA;
  logic [15:0] descCountB;

  int total = 0;
  int bad = 0;
  int waitCycles = 0;
  int rdyCnt = 0;
  int accCnt = 0;
  logic [24:0] accLog [0:15];
  bit pend = 1'b0;
  logic [24:0] pendKey = '0;
  int holdErr = 0;

  logic [23:0] eStart = '0;
  logic [31:0] eW0 = '0;
  logic [31:0] eW1 = '0;
  logic [31:0] eW2 = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  desc_fetch_seq uut (
    .clk(clk), .rstN(rstN), .actValid(actValid), .actVector(actVector),
    .chainReq(chainReq), .memReq(memReq), .memHalf(memHalf), .memAddr(memAddr),
    .memReady(memReady), .memRdata(memRdata), .busy(busy), .fetchDone(fetchDone),
    .fetchErr(fetchErr), .descAddr(descAddr), .descModeA(descModeA), .descSrc(descSrc),
    .descModeB(descModeB), .descDst(descDst), .descCountA(descCountA),
    .descCountB(descCountB)
  );

  // pointer stored for each vector; chosen to hit every acceptance boundary
  function automatic logic [15:0] ptrOf(input int v);
    case (v)
      0:   return 16'hEC00;
      124: return 16'hEBFC;
      125: return 16'hF000;
      126: return 16'hEFF4;
      default: begin
        if (v % 32 == 9) return 16'(16'hEB00 + v);
        if (v % 16 == 5) return 16'(16'hEC02 + v * 8);
        return 16'(16'hEC00 + v * 8);
      end
    endcase
  endfunction

  function automatic logic [31:0] wordAt(input logic [23:0] a);
    return {a[7:0] ^ 8'hA5, a ^ 24'h3C3C3C};
  endfunction

  function automatic logic [31:0] halfAt(input logic [23:0] a);
    if (a >= 24'h000400 && a < 24'h000500 && !a[0])
      return {16'hDEAD, ptrOf(int'((a - 24'h000400) >> 1))};
    return 32'hBAD0BAD0;
  endfunction

  function automatic bit okStart(input logic [23:0] s);
    return (s[1:0] == 2'b00) && (s >= 24'hFFEC00) && (s <= 24'hFFEFF4);
  endfunction

  // memory model: grants after waitCycles, logs every completed access
  always @(negedge clk) begin
    if (pend && (!memReq || {memHalf, memAddr} != pendKey)) holdErr++;
    pend = 1'b0;
    if (!memReq) begin
      memReady <= 1'b0;
      rdyCnt = 0;
    end else if (rdyCnt >= waitCycles) begin
      memReady <= 1'b1;
      memRdata <= memHalf ? halfAt(memAddr) : wordAt(memAddr);
      accLog[accCnt % 16] = {memHalf, memAddr};
      accCnt++;
      rdyCnt = 0;
    end else begin
      memReady <= 1'b0;
      rdyCnt++;
      pend = 1'b1;
      pendKey = {memHalf, memAddr};
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic runFetch(input bit useVec, input logic [6:0] vec, input bit useChain,
                          input bit interfere, output int lat, output bit gotDone,
                          output bit gotErr, output int startIdx, output bit busyEarly);
    @(negedge clk);
    actValid  = useVec;
    actVector = vec;
    chainReq  = useChain;
    startIdx  = accCnt;
    @(negedge clk);
    actValid  = 1'b0;
    chainReq  = 1'b0;
    lat       = 1;
    busyEarly = busy;
    while (!(fetchDone || fetchErr) && lat < 200) begin
      @(negedge clk);
      lat++;
      if (interfere && lat == 2) begin
        actValid  = 1'b1;
        actVector = vec ^ 7'h01;
        chainReq  = 1'b1;
      end else if (interfere && lat == 3) begin
        actValid = 1'b0;
        chainReq = 1'b0;
      end
    end
    gotDone = fetchDone;
    gotErr  = fetchErr;
  endtask

  task automatic checkQuiet(input string req);
    @(negedge clk);
    chk(req, "pulse cleared", {30'd0, fetchDone, fetchErr}, 32'd0);
    chk(req, "busy after end", {31'd0, busy}, 32'd0);
  endtask

  task automatic checkFields(input string req);
    chk(req, "descAddr", {8'd0, descAddr}, {8'd0, eStart});
    chk("R3", {req, " modeA"}, {24'd0, descModeA}, {24'd0, eW0[31:24]});
    chk("R3", {req, " src"}, {8'd0, descSrc}, {8'd0, eW0[23:0]});
    chk("R3", {req, " modeB"}, {24'd0, descModeB}, {24'd0, eW1[31:24]});
    chk("R3", {req, " dst"}, {8'd0, descDst}, {8'd0, eW1[23:0]});
    chk("R3", {req, " countA"}, {16'd0, descCountA}, {16'd0, eW2[31:16]});
    chk("R3", {req, " countB"}, {16'd0, descCountB}, {16'd0, eW2[15:0]});
  endtask

  task automatic expectLoad(input logic [23:0] s);
    eStart = s;
    eW0 = wordAt(s);
    eW1 = wordAt(s + 24'd4);
    eW2 = wordAt(s + 24'd8);
  endtask

  task automatic checkWords(input int firstIdx, input logic [23:0] s);
    for (int i = 0; i < 3; i++) begin
      chk("R2", "word access", {7'd0, accLog[(firstIdx + i) % 16]},
          {7'd0, 1'b0, s + 24'(4 * i)});
    end
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    int lat;
    bit gotDone;
    bit gotErr;
    int startIdx;
    bit busyEarly;
    logic [23:0] s;

    // R11: reset state
    repeat (3) @(negedge clk);
    chk("R11", "busy/memReq", {30'd0, busy, memReq}, 32'd0);
    chk("R11", "pulses", {30'd0, fetchDone, fetchErr}, 32'd0);
    checkFields("R11");
    rstN = 1'b1;

    // R6: chain before any descriptor has been loaded
    runFetch(1'b0, 7'd0, 1'b1, 1'b0, lat, gotDone, gotErr, startIdx, busyEarly);
    chk("R6", "no-desc chain err", {31'd0, gotErr}, 32'd1);
    chk("R6", "no-desc chain latency", lat, 32'd1);
    chk("R6", "no-desc chain accesses", accCnt - startIdx, 32'd0);
    checkFields("R6");
    checkQuiet("R6");

    // sweep over all vectors with varying wait states (R1, R2, R3, R4, R5, R7)
    for (int v = 0; v < 128; v++) begin
      waitCycles = v % 3;
      s = {8'hFF, ptrOf(v)};
      runFetch(1'b1, 7'(v), 1'b0, 1'b0, lat, gotDone, gotErr, startIdx, busyEarly);
      chk("R1", "vector access", {7'd0, accLog[startIdx % 16]},
          {7'd0, 1'b1, 24'h000400 + 24'(2 * v)});
      chk("R7", "busy after accept", {31'd0, busyEarly}, 32'd1);
      if (okStart(s)) begin
        expectLoad(s);
        chk("R7", "done", {31'd0, gotDone}, 32'd1);
        chk("R7", "done latency", lat, 4 * (waitCycles + 1) + 1);
        chk("R2", "access count", accCnt - startIdx, 32'd4);
        checkWords(startIdx + 1, s);
        checkFields("R2");
      end else if (s[1:0] != 2'b00) begin
        chk("R4", "misaligned err", {31'd0, gotErr}, 32'd1);
        chk("R4", "err latency", lat, waitCycles + 2);
        chk("R4", "access count", accCnt - startIdx, 32'd1);
        checkFields("R4");
      end else begin
        chk("R5", "window err", {31'd0, gotErr}, 32'd1);
        chk("R5", "err latency", lat, waitCycles + 2);
        chk("R5", "access count", accCnt - startIdx, 32'd1);
        checkFields("R5");
      end
      checkQuiet("R7");
    end

    // R6: chain from the last start that fits leaves the window
    waitCycles = 0;
    runFetch(1'b0, 7'd0, 1'b1, 1'b0, lat, gotDone, gotErr, startIdx, busyEarly);
    chk("R6", "overflow chain err", {31'd0, gotErr}, 32'd1);
    chk("R6", "overflow chain latency", lat, 32'd1);
    chk("R6", "overflow chain accesses", accCnt - startIdx, 32'd0);
    checkFields("R6");
    checkQuiet("R6");

    // R6: walk the chain from the window base to its end
    waitCycles = 1;
    runFetch(1'b1, 7'd0, 1'b0, 1'b0, lat, gotDone, gotErr, startIdx, busyEarly);
    expectLoad(24'hFFEC00);
    checkFields("R6");
    checkQuiet("R6");
    for (int k = 1; k < 100; k++) begin
      waitCycles = k % 2;
      s = 24'hFFEC00 + 24'(12 * k);
      runFetch(1'b0, 7'd0, 1'b1, 1'b0, lat, gotDone, gotErr, startIdx, busyEarly);
      if (okStart(s)) begin
        expectLoad(s);
        chk("R6", "chain done", {31'd0, gotDone}, 32'd1);
        chk("R7", "chain latency", lat, 3 * (waitCycles + 1) + 1);
        chk("R6", "chain access count", accCnt - startIdx, 32'd3);
        checkWords(startIdx, s);
        checkFields("R6");
        checkQuiet("R7");
      end else begin
        chk("R6", "chain end err", {31'd0, gotErr}, 32'd1);
        chk("R6", "chain end latency", lat, 32'd1);
        chk("R6", "chain end accesses", accCnt - startIdx, 32'd0);
        checkFields("R6");
        checkQuiet("R6");
        break;
      end
    end

    // R10: activation wins over a simultaneous chain request
    waitCycles = 0;
    runFetch(1'b1, 7'd7, 1'b1, 1'b0, lat, gotDone, gotErr, startIdx, busyEarly);
    chk("R10", "first access is vector read", {7'd0, accLog[startIdx % 16]},
        {7'd0, 1'b1, 24'h00040E});
    chk("R10", "access count", accCnt - startIdx, 32'd4);
    expectLoad({8'hFF, ptrOf(7)});
    checkFields("R10");
    checkQuiet("R10");

    // R9: requests during a fetch are ignored
    waitCycles = 3;
    runFetch(1'b1, 7'd1, 1'b0, 1'b1, lat, gotDone, gotErr, startIdx, busyEarly);
    chk("R9", "done", {31'd0, gotDone}, 32'd1);
    chk("R9", "latency", lat, 32'd17);
    chk("R9", "access count", accCnt - startIdx, 32'd4);
    expectLoad({8'hFF, ptrOf(1)});
    checkWords(startIdx + 1, eStart);
    checkFields("R9");
    checkQuiet("R9");
    chk("R9", "no later access", accCnt - startIdx, 32'd4);

    // R8: request held while waiting
    chk("R8", "hold violations", holdErr, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule